// File: doc/BRIEF.md
# Programmable Tag Check Unit

This block sits beside a processor pipeline that carries a one-bit taint tag with every register value, memory word and program counter. Each cycle it receives an instruction's class flags together with the tags of its operands, of its load/store addresses and data, and of the program counter. It compares them against a 22-bit policy word that software has written into a check register elsewhere in the core. When tagged (untrusted) data is about to be used in a way that the policy forbids, the unit emits a one-cycle security exception together with a cause code naming the class and the operand role that failed. Trap entry is left to the core.

The policy is split into per-class fields. Each field has one enable per operand role. Load/store has four separate enables, one each for source address, source data, destination data and destination address. A single execute bit traps on a tagged program counter. Tagged values flowing through a class whose enables are clear pass silently. Ordinary computation on untrusted inputs therefore never traps, while control transfers to, or memory accesses through, untrusted values do. The result is registered, so the exception appears on the cycle after the instruction is presented.

Top module: `tagchk_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `exc_o` is 0 and `cause_o` is 0.
- R2: When a valid instruction has `tag_pc_i` set and execute enable `policy_i[17]` is set, the next cycle shows `exc_o`=1 with `cause_o`=28 (class code 7, role 0).
- R3: When a valid instruction has `class_i[6]` (load/store) set, enable `policy_i[18+r]` together with `tag_ls_i[r]` traps. The roles are r=0 source address, 1 source data, 2 destination data and 3 destination address. The cause is 6*4+r, and the lowest failing r is reported.
- R4: For class k in 0..5 (0 arithmetic, 1 branch, 2 jump, 3 shift, 4 logical, 5 comparison), the field starts at bit 3k. Role 0 checks `tag_op1_i`, role 1 checks `tag_op2_i` and role 2 checks `tag_dst_i` (the result, or the branch/jump target). Comparison has only roles 0 and 1, at bits 16:15. When `class_i[k]` is set and an enabled role's tag is set, the cause is 4k+role, and the lowest failing role is reported.
- R5: Set tags whose enable bits are clear raise no exception.
- R6: When `valid_i` is low, no exception is raised on the next cycle, whatever the other inputs hold.
- R7: When several checks fail together, the execute check wins over load/store, and load/store wins over the other classes. Among those classes the lowest k wins.
- R8: `exc_o` is high for exactly the cycle after each failing instruction. Whenever `exc_o` is low, `cause_o` is 0.
- R9: A class whose `class_i` bit is clear is not checked, even if its field is enabled and its tags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 22 | Check policy word |
| valid_i | input | 1 | An instruction is presented this cycle |
| class_i | input | 7 | Class flags, bit 6 load/store, bits 5..0 as in R4 |
| tag_op1_i | input | 1 | Tag of source operand 1 |
| tag_op2_i | input | 1 | Tag of source operand 2 |
| tag_dst_i | input | 1 | Tag of result or control-transfer target |
| tag_pc_i | input | 1 | Tag of the program counter |
| tag_ls_i | input | 4 | Load/store role tags, indexed as in R3 |
| exc_o | output | 1 | Security exception pulse |
| cause_o | output | 5 | Class code in bits 4:2, role in bits 1:0 |

## Verification
The interesting collision is a tagged program counter arriving in the same cycle as a failing load/store role or a failing class operand. A single instruction may also carry several class flags that each fail at once. The bench builds such instructions deliberately, with every tag set and several enables on. It also runs a long stretch of random policy words, class sets and tags. A behavioural model in the bench walks the checks in priority order and compares its prediction with the registered outputs on every cycle. The reported cause must always be the winning check and never a merge of two checks.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  localparam int POL_W    = 22;
  localparam int NCLS     = 6;
  localparam int LS_ROLES = 4;
  localparam int ROLE_W   = 2;
  localparam int CID_W    = 3;
  localparam int CAUSE_W  = CID_W + ROLE_W;
  localparam int CLS_W    = NCLS + 1;
  localparam int EXEC_BIT = 17;
  localparam int LS_LSB   = 18;
  localparam logic [CID_W-1:0] CID_LS = 3'd6;
  localparam logic [CID_W-1:0] CID_PC = 3'd7;

  // field position of ordinary class k
  function automatic int cls_lsb(int k);
    return 3 * k;
  endfunction

  // comparison class carries source enables only
  function automatic int cls_width(int k);
    return (k == NCLS - 1) ? 2 : 3;
  endfunction

  // index of lowest set bit, 0 when none
  function automatic logic [ROLE_W-1:0] first_role(logic [LS_ROLES-1:0] v);
    logic [ROLE_W-1:0] r;
    r = '0;
    for (int i = LS_ROLES - 1; i >= 0; i--)
      if (v[i]) r = ROLE_W'(i);
    return r;
  endfunction

  function automatic logic [CAUSE_W-1:0] make_cause(logic [CID_W-1:0] cid,
                                                    logic [ROLE_W-1:0] role);
    return {cid, role};
  endfunction
endpackage

// File: rtl/tagchk_field.sv
module tagchk_field
  import tagchk_pkg::*;
#(
  parameter int W = 3
) (
  input  logic              act,
  input  logic [W-1:0]      en,
  input  logic [W-1:0]      tags,
  output logic              hit,
  output logic [ROLE_W-1:0] role
);
  logic [W-1:0]        fail;
  logic [LS_ROLES-1:0] fail_ext;

  always_comb begin
    fail     = en & tags & {W{act}};
    fail_ext = '0;
    fail_ext[W-1:0] = fail;
    hit  = |fail;
    role = first_role(fail_ext);
  end
endmodule

// File: rtl/tagchk_top.sv
module tagchk_top
  import tagchk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [POL_W-1:0]   policy_i,
  input  logic               valid_i,
  input  logic [CLS_W-1:0]   class_i,
  input  logic               tag_op1_i,
  input  logic               tag_op2_i,
  input  logic               tag_dst_i,
  input  logic               tag_pc_i,
  input  logic [LS_ROLES-1:0] tag_ls_i,
  output logic               exc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [2:0]        op_tags;
  logic              pc_hit;
  logic              ls_hit;
  logic [ROLE_W-1:0] ls_role;
  logic [NCLS-1:0]   cls_hit;
  logic [ROLE_W-1:0] cls_role [NCLS];
  logic              any_hit;
  logic [CAUSE_W-1:0] nxt_cause;

  assign op_tags = {tag_dst_i, tag_op2_i, tag_op1_i};
  assign pc_hit  = valid_i & policy_i[EXEC_BIT] & tag_pc_i;

  tagchk_field #(.W(LS_ROLES)) u_ls (
    .act  (valid_i & class_i[NCLS]),
    .en   (policy_i[LS_LSB +: LS_ROLES]),
    .tags (tag_ls_i),
    .hit  (ls_hit),
    .role (ls_role)
  );

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    localparam int W = cls_width(k);
    localparam int L = cls_lsb(k);
    tagchk_field #(.W(W)) u_fld (
      .act  (valid_i & class_i[k]),
      .en   (policy_i[L +: W]),
      .tags (op_tags[W-1:0]),
      .hit  (cls_hit[k]),
      .role (cls_role[k])
    );
  end

  assign any_hit = pc_hit | ls_hit | (|cls_hit);

  always_comb begin
    nxt_cause = '0;
    for (int k = NCLS - 1; k >= 0; k--)
      if (cls_hit[k]) nxt_cause = make_cause(CID_W'(k), cls_role[k]);
    if (ls_hit) nxt_cause = make_cause(CID_LS, ls_role);
    if (pc_hit) nxt_cause = make_cause(CID_PC, '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_o   <= 1'b0;
      cause_o <= '0;
    end else begin
      exc_o   <= any_hit;
      cause_o <= nxt_cause;
    end
  end
endmodule

// File: rtl/tagchk_sva.sv
module tagchk_sva
  import tagchk_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [POL_W-1:0]   policy_i,
  input logic               valid_i,
  input logic [CLS_W-1:0]   class_i,
  input logic               tag_pc_i,
  input logic [LS_ROLES-1:0] tag_ls_i,
  input logic               pc_hit,
  input logic               ls_hit,
  input logic [NCLS-1:0]    cls_hit,
  input logic               exc_o,
  input logic [CAUSE_W-1:0] cause_o
);
  AST_PC_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && policy_i[EXEC_BIT] && tag_pc_i) |=> (exc_o && cause_o == 5'd28)); // R2

  AST_LS_BEATS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !(policy_i[EXEC_BIT] && tag_pc_i) && class_i[6] &&
     (|(policy_i[LS_LSB +: LS_ROLES] & tag_ls_i))) |=> (exc_o && cause_o[4:2] == 3'd6)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !exc_o); // R6

  AST_POLICY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && policy_i == '0) |=> !exc_o); // R5

  AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_o |-> (cause_o == '0)); // R8

  AST_HIT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_hit || ls_hit || (|cls_hit)) |=> exc_o); // R8

  AST_NO_HIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_hit || ls_hit || (|cls_hit)) |=> !exc_o); // R8
endmodule

bind tagchk_top tagchk_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .policy_i (policy_i),
  .valid_i  (valid_i),
  .class_i  (class_i),
  .tag_pc_i (tag_pc_i),
  .tag_ls_i (tag_ls_i),
  .pc_hit   (pc_hit),
  .ls_hit   (ls_hit),
  .cls_hit  (cls_hit),
  .exc_o    (exc_o),
  .cause_o  (cause_o)
);

// File: tb/sim_tagchk_top.sv
`timescale 1ns/1ps
module sim_tagchk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] pol = '0;
  logic        valid = 1'b0;
  logic [6:0]  cls = '0;
  logic        t1 = 0, t2 = 0, td = 0, tpc = 0;
  logic [3:0]  tls = '0;
  logic        exc;
  logic [4:0]  cause;

  int n_chk = 0;
  int n_bad = 0;
  bit chk_on = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [5:0] exp_q = '0;

  always #5 clk = ~clk;

  tagchk_top u0 (
    .clk(clk), .rst_n(rst_n), .policy_i(pol), .valid_i(valid), .class_i(cls),
    .tag_op1_i(t1), .tag_op2_i(t2), .tag_dst_i(td), .tag_pc_i(tpc),
    .tag_ls_i(tls), .exc_o(exc), .cause_o(cause)
  );

  // behavioural model: walk checks in priority order, first failure wins
  function automatic logic [5:0] model();
    int n;
    logic t;
    if (!valid) return 6'd0;
    if (pol[17] && tpc) return {1'b1, 5'd28};
    if (cls[6])
      for (int r = 0; r < 4; r++)
        if (pol[18 + r] && tls[r]) return {1'b1, 5'(24 + r)};
    for (int k = 0; k < 6; k++) begin
      if (!cls[k]) continue;
      n = (k == 5) ? 2 : 3;
      for (int r = 0; r < n; r++) begin
        t = (r == 0) ? t1 : (r == 1) ? t2 : td;
        if (pol[3 * k + r] && t) return {1'b1, 5'(4 * k + r)};
      end
    end
    return 6'd0;
  endfunction

  always @(posedge clk) exp_q <= rst_n ? model() : 6'd0;

  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if ({exc, cause} !== exp_q) begin
        n_bad++;
        $display("FAIL %s: exc/cause actual %0b/%0d expected %0b/%0d",
                 cur_req, exc, cause, exp_q[5], exp_q[4:0]);
      end
    end
  end

  task automatic apply(input logic [21:0] p, input logic v, input logic [6:0] c,
                       input logic a, input logic b, input logic d,
                       input logic pc, input logic [3:0] l);
    @(negedge clk);
    pol = p; valid = v; cls = c; t1 = a; t2 = b; td = d; tpc = pc; tls = l;
  endtask

  task automatic idle();
    apply('0, 0, '0, 0, 0, 0, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    n_chk++;
    if (exc !== 1'b0 || cause !== 5'd0) begin
      n_bad++;
      $display("FAIL R1: exc/cause actual %0b/%0d expected 0/0", exc, cause);
    end
    rst_n = 1'b1;
    chk_on = 1;
    idle();

    cur_req = "R2";
    apply(22'h020000, 1, 7'h00, 0, 0, 0, 1, '0);
    apply(22'h020000, 1, 7'h01, 1, 1, 1, 1, '0);
    idle();

    cur_req = "R3";
    for (int r = 0; r < 4; r++) apply(22'(1) << (18 + r), 1, 7'h40, 0, 0, 0, 0, 4'(1 << r));
    apply(22'h3C0000, 1, 7'h40, 0, 0, 0, 0, 4'b1100);
    apply(22'h3C0000, 1, 7'h40, 0, 0, 0, 0, 4'b1111);
    idle();

    cur_req = "R4";
    for (int k = 0; k < 6; k++)
      for (int r = 0; r < 3; r++)
        apply(22'(1) << (3 * k + r), 1, 7'(1 << k), r == 0, r == 1, r == 2, 0, '0);
    apply(22'h007FFF, 1, 7'h02, 0, 1, 1, 0, '0);
    idle();

    cur_req = "R5";
    apply(22'h3FFFF8, 1, 7'h01, 1, 1, 1, 0, '0);
    apply(22'h01FFFF, 1, 7'h3F, 0, 0, 0, 1, 4'hF);
    apply(22'h000000, 1, 7'h7F, 1, 1, 1, 1, 4'hF);

    cur_req = "R6";
    apply(22'h3FFFFF, 0, 7'h7F, 1, 1, 1, 1, 4'hF);
    apply(22'h3FFFFF, 0, 7'h01, 1, 0, 0, 1, 4'h1);

    cur_req = "R9";
    apply(22'h3DFFFF, 1, 7'h00, 1, 1, 1, 0, 4'hF);
    apply(22'h3DFFFF, 1, 7'h20, 0, 0, 1, 0, 4'hF);

    cur_req = "R7";
    apply(22'h3FFFFF, 1, 7'h7F, 1, 1, 1, 1, 4'hF);
    apply(22'h3DFFFF, 1, 7'h7F, 1, 1, 1, 1, 4'h8);
    apply(22'h1DFFFF, 1, 7'h7F, 1, 1, 1, 1, 4'h8);
    apply(22'h007E00, 1, 7'h38, 0, 0, 1, 0, '0);

    cur_req = "R8";
    apply(22'h000001, 1, 7'h01, 1, 0, 0, 0, '0);
    apply(22'h000001, 1, 7'h01, 0, 0, 0, 0, '0);
    apply(22'h000001, 1, 7'h01, 1, 0, 0, 0, '0);
    apply(22'h000001, 1, 7'h01, 1, 0, 0, 0, '0);
    idle();

    cur_req = "R7";
    for (int i = 0; i < 2000; i++)
      apply(22'($urandom), ($urandom % 8) != 0, 7'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
            4'($urandom));
    idle();
    idle();
    chk_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule